// File: doc/BRIEF.md
# Floating-Point Compare Condition Evaluator

This block takes two IEEE-754 operands, either both single precision or both double precision, and produces one Boolean that says whether a chosen relation between them holds. The relation comes from a 4-bit condition field. Three of its bits pick any combination of "less than", "equal" and "unordered", and the result is the OR of the picked relations that actually hold. The fourth bit asks for strict handling of NaNs, so that even a quiet NaN raises the invalid-operation flag.

The evaluator is purely combinational. A pipeline stage or a condition register around it belongs to the surrounding datapath. Single-precision operands occupy the low 32 bits of each 64-bit input, and the upper half is ignored. An absolute-value option compares the magnitudes and ignores both signs.

Top module: `fpcmp_eval`

## Requirements
- R1: Bit 2 of `cond_sel` selects less-than, bit 1 selects equal and bit 0 selects unordered. `cond_true` is the OR of the selected relations that hold, so `cond_sel[2:0]` = 3'b000 always gives 0.
- R2: When either operand is a NaN (exponent all ones, fraction non-zero), the pair is unordered, and less-than and equal are both false.
- R3: When a NaN is present and `cond_sel[3]` is 1, `invalid` is 1, even if every NaN is quiet (fraction MSB set).
- R4: When either operand is a signalling NaN (exponent all ones, fraction non-zero, fraction MSB clear), `invalid` is 1 whatever `cond_sel[3]` is.
- R5: `invalid` is 0 whenever neither operand is a NaN. This includes infinities and zeros.
- R6: With `abs_en` = 1, both sign bits are treated as clear before comparing, so -x equals +x and -2 is not less than +1.
- R7: +0 and -0 compare as equal and neither is less than the other.
- R8: With `fmt_dbl` = 0, the sign is bit 31, the exponent is bits 30:23 and the fraction is bits 22:0. Bits 63:32 have no effect on either output.
- R9: With `fmt_dbl` = 1, the sign is bit 63, the exponent is bits 62:52 and the fraction is bits 51:0. Ordering is the numeric order of the values, and -inf < negatives < zero < positives < +inf.
- R10: Less-than holds only when the operands are not equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 64 | First operand (left side of less-than) |
| op_b | input | 64 | Second operand |
| fmt_dbl | input | 1 | 1 = double precision, 0 = single precision in the low half |
| abs_en | input | 1 | 1 = compare magnitudes only |
| cond_sel | input | 4 | Bit 3 strict-NaN, bit 2 less, bit 1 equal, bit 0 unordered |
| cond_true | output | 1 | Condition result |
| invalid | output | 1 | Invalid-operation status |

## Verification
The two outputs are produced together. In any one evaluation the block can report a true condition through the unordered bit and raise invalid through strict mode or a signalling NaN. The stimulus therefore pairs NaN classes with every condition code, including codes whose unordered bit makes `cond_true` high while `invalid` is high, and codes whose strict bit is clear while a signalling NaN still forces `invalid`. Each case judges both outputs against a bench model built on an integer ordering key, with the NaN classes derived separately from the stated bit fields.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
  parameter int OP_W  = 64;
  parameter int MAG_W = OP_W - 1;

  typedef struct packed {
    logic             sign;
    logic [MAG_W-1:0] mag;
    logic             nan;
    logic             snan;
    logic             zero;
  } fp_class_t;

  typedef enum logic [1:0] {
    CB_UNORD = 2'd0,
    CB_EQ    = 2'd1,
    CB_LT    = 2'd2,
    CB_STRICT = 2'd3
  } cond_bit_e;
endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
  import fpcmp_pkg::*;
#(
  parameter int SE = 8,
  parameter int SF = 23,
  parameter int DE = 11,
  parameter int DF = 52
) (
  input  logic [OP_W-1:0] op,
  input  logic            fmt_dbl,
  input  logic            abs_en,
  output fp_class_t       info
);
  logic [SE-1:0] s_exp;
  logic [SF-1:0] s_frac;
  logic [DE-1:0] d_exp;
  logic [DF-1:0] d_frac;
  logic          raw_sign, exp_ones, frac_nz, quiet_bit;
  logic [MAG_W-1:0] mag;

  assign s_exp  = op[SF +: SE];
  assign s_frac = op[SF-1:0];
  assign d_exp  = op[DF +: DE];
  assign d_frac = op[DF-1:0];

  always_comb begin
    if (fmt_dbl) begin
      raw_sign  = op[DE+DF];
      mag       = MAG_W'({d_exp, d_frac});
      exp_ones  = &d_exp;
      frac_nz   = |d_frac;
      quiet_bit = d_frac[DF-1];
    end else begin
      raw_sign  = op[SE+SF];
      mag       = MAG_W'({s_exp, s_frac});
      exp_ones  = &s_exp;
      frac_nz   = |s_frac;
      quiet_bit = s_frac[SF-1];
    end
  end

  always_comb begin
    info.sign = raw_sign & ~abs_en;
    info.mag  = mag;
    info.nan  = exp_ones & frac_nz;
    info.snan = exp_ones & frac_nz & ~quiet_bit;
    info.zero = (mag == '0);
  end
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
  import fpcmp_pkg::*;
(
  input  fp_class_t a,
  input  fp_class_t b,
  output logic      is_eq,
  output logic      is_lt
);
  logic mag_lt, mag_gt;
  assign mag_lt = (a.mag < b.mag);
  assign mag_gt = (a.mag > b.mag);

  always_comb begin
    is_eq = (a.zero && b.zero) || ((a.sign == b.sign) && (a.mag == b.mag));
    if (a.sign != b.sign)
      is_lt = a.sign;
    else if (a.sign)
      is_lt = mag_gt;
    else
      is_lt = mag_lt;
    is_lt = is_lt & ~is_eq;
  end
endmodule

// File: rtl/fpcmp_eval.sv
module fpcmp_eval
  import fpcmp_pkg::*;
#(
  parameter int SE = 8,
  parameter int SF = 23,
  parameter int DE = 11,
  parameter int DF = 52
) (
  input  logic [63:0] op_a,
  input  logic [63:0] op_b,
  input  logic        fmt_dbl,
  input  logic        abs_en,
  input  logic [3:0]  cond_sel,
  output logic        cond_true,
  output logic        invalid
);
  localparam int N_OPS = 2;

  logic [OP_W-1:0] ops [N_OPS];
  fp_class_t       cls [N_OPS];
  logic            rel_eq, rel_lt, unord, any_snan;

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar g = 0; g < N_OPS; g++) begin : g_cls
    fpcmp_classify #(.SE(SE), .SF(SF), .DE(DE), .DF(DF)) u_cls (
      .op     (ops[g]),
      .fmt_dbl(fmt_dbl),
      .abs_en (abs_en),
      .info   (cls[g])
    );
  end

  fpcmp_order u_ord (
    .a    (cls[0]),
    .b    (cls[1]),
    .is_eq(rel_eq),
    .is_lt(rel_lt)
  );

  always_comb begin
    unord    = cls[0].nan | cls[1].nan;
    any_snan = cls[0].snan | cls[1].snan;
    cond_true = (cond_sel[CB_LT]    & rel_lt & ~unord)
              | (cond_sel[CB_EQ]    & rel_eq & ~unord)
              | (cond_sel[CB_UNORD] & unord);
    invalid   = unord & (cond_sel[CB_STRICT] | any_snan);
  end
endmodule

// File: rtl/fpcmp_eval_chk.sv
module fpcmp_eval_chk (
  input logic [63:0] op_a,
  input logic [63:0] op_b,
  input logic        fmt_dbl,
  input logic        abs_en,
  input logic [3:0]  cond_sel,
  input logic        cond_true,
  input logic        invalid
);
  logic a_nan, b_nan, a_sn, b_sn, a_z, b_z;

  always_comb begin
    if (fmt_dbl) begin
      a_nan = (op_a[62:52] == 11'h7FF) && (op_a[51:0] != 0);
      b_nan = (op_b[62:52] == 11'h7FF) && (op_b[51:0] != 0);
      a_sn  = a_nan && !op_a[51];
      b_sn  = b_nan && !op_b[51];
      a_z   = (op_a[62:0] == 0);
      b_z   = (op_b[62:0] == 0);
    end else begin
      a_nan = (op_a[30:23] == 8'hFF) && (op_a[22:0] != 0);
      b_nan = (op_b[30:23] == 8'hFF) && (op_b[22:0] != 0);
      a_sn  = a_nan && !op_a[22];
      b_sn  = b_nan && !op_b[22];
      a_z   = (op_a[30:0] == 0);
      b_z   = (op_b[30:0] == 0);
    end
  end

  always_comb begin
    if ((a_nan || b_nan) && cond_sel[0])
      AST_UNORD_SELECTED: assert (cond_true); // R1
    if ((a_nan || b_nan) && cond_sel[0] == 1'b0)
      AST_NAN_NOT_LT_EQ: assert (!cond_true); // R2
    if ((a_nan || b_nan) && cond_sel[3])
      AST_STRICT_QNAN: assert (invalid); // R3
    if (a_sn || b_sn)
      AST_SNAN_INVALID: assert (invalid); // R4
    if (!a_nan && !b_nan)
      AST_NO_NAN_VALID: assert (!invalid); // R5
    if (a_z && b_z && cond_sel[2:0] == 3'b010)
      AST_ZERO_EQUAL: assert (cond_true); // R7
    if (cond_sel[2:0] == 3'b000)
      AST_EMPTY_SELECT: assert (!cond_true); // R1
    if (abs_en && !a_nan && !b_nan && cond_sel[2:0] == 3'b010 &&
        ((fmt_dbl && op_a[62:0] == op_b[62:0]) || (!fmt_dbl && op_a[30:0] == op_b[30:0])))
      AST_ABS_EQUAL: assert (cond_true); // R6
  end
endmodule

bind fpcmp_eval fpcmp_eval_chk u_chk (
  .op_a     (op_a),
  .op_b     (op_b),
  .fmt_dbl  (fmt_dbl),
  .abs_en   (abs_en),
  .cond_sel (cond_sel),
  .cond_true(cond_true),
  .invalid  (invalid)
);

// File: tb/fpcmp_eval_test.sv
module fpcmp_eval_test;
  logic        clk;
  logic        rst_n;
  logic [63:0] op_a, op_b;
  logic        fmt_dbl, abs_en;
  logic [3:0]  cond_sel;
  logic        cond_true, invalid;
  int          n_checks = 0;
  int          n_fail   = 0;
  bit          done     = 0;

  fpcmp_eval uut (
    .op_a(op_a), .op_b(op_b), .fmt_dbl(fmt_dbl), .abs_en(abs_en),
    .cond_sel(cond_sel), .cond_true(cond_true), .invalid(invalid)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  function automatic bit m_nan(logic [63:0] v, bit d);
    return d ? (v[62:52] == 11'h7FF && v[51:0] != 0) : (v[30:23] == 8'hFF && v[22:0] != 0);
  endfunction
  function automatic bit m_snan(logic [63:0] v, bit d);
    return m_nan(v, d) && (d ? !v[51] : !v[22]);
  endfunction
  function automatic logic [63:0] m_key(logic [63:0] v, bit d, bit ab);
    logic [63:0] mag;
    bit s;
    mag = d ? {1'b0, v[62:0]} : {33'b0, v[30:0]};
    s   = (d ? v[63] : v[31]) && !ab;
    if (mag == 0) return 64'h8000_0000_0000_0000;
    return s ? 64'h8000_0000_0000_0000 - mag : 64'h8000_0000_0000_0000 + mag;
  endfunction

  task automatic apply(logic [63:0] a, logic [63:0] b, bit d, bit ab, logic [3:0] c, string tag);
    bit un, lt, eq, er, ei;
    op_a = a; op_b = b; fmt_dbl = d; abs_en = ab; cond_sel = c;
    un = m_nan(a, d) || m_nan(b, d);
    eq = !un && m_key(a, d, ab) == m_key(b, d, ab);
    lt = !un && m_key(a, d, ab) <  m_key(b, d, ab);
    er = (c[2] && lt) || (c[1] && eq) || (c[0] && un);
    ei = un && (c[3] || m_snan(a, d) || m_snan(b, d));
    #1;
    n_checks++;
    if (cond_true !== er || invalid !== ei) begin
      n_fail++;
      $display("FAIL %s: a=%h b=%h d=%0d abs=%0d c=%b got res=%b inv=%b expected res=%b inv=%b",
               tag, a, b, d, ab, c, cond_true, invalid, er, ei);
    end
    @(posedge clk);
  endtask

  function automatic logic [63:0] gen_op(bit d, int cls, logic [63:0] other);
    logic [63:0] r;
    r = {$urandom, $urandom};
    case (cls)
      1: r = d ? {r[63], 63'b0} : {r[63:32], r[31], 31'b0};
      2: r = d ? {r[63], 11'h7FF, 52'b0} : {r[63:32], r[31], 8'hFF, 23'b0};
      3: r = d ? {r[63], 11'h7FF, 1'b1, r[50:0]} : {r[63:32], r[31], 8'hFF, 1'b1, r[21:0]};
      4: r = d ? {r[63], 11'h7FF, 1'b0, r[50:1], 1'b1} : {r[63:32], r[31], 8'hFF, 1'b0, r[21:1], 1'b1};
      5: r = other ^ (d ? {r[63], 63'b0} : {r[63:32], r[31], 31'b0});
      6: r = d ? {r[63:61], 11'h3FF ^ {9'b0, r[1:0]}, r[49:0]} : {r[63:32], r[31], 8'h7F ^ {6'b0, r[1:0]}, r[22:0]};
      default: ;
    endcase
    return r;
  endfunction

  initial begin
    #100000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] a, b;
    void'($urandom(32'd1357));
    rst_n = 0; op_a = 0; op_b = 0; fmt_dbl = 0; abs_en = 0; cond_sel = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    // reset state: zero inputs, empty selection (R1)
    apply(64'h0, 64'h0, 0, 0, 4'b0000, "R1 reset idle");
    apply(64'h0, 64'h8000_0000_0000_0000, 1, 0, 4'b0010, "R7 dbl +0 == -0");
    apply(64'h0000_0000_8000_0000, 64'h0, 0, 0, 4'b0100, "R7 sgl -0 not < +0");
    apply(64'h0000_0000_BF80_0000, 64'h0000_0000_3F80_0000, 0, 0, 4'b0100, "R9 -1 < 1 sgl");
    apply(64'h0000_0000_BF80_0000, 64'h0000_0000_3F80_0000, 0, 1, 4'b0010, "R6 |-1| == |1|");
    apply(64'h0000_0000_C000_0000, 64'h0000_0000_3F80_0000, 0, 1, 4'b0100, "R6 |-2| not < 1");
    apply(64'h0000_0000_7FC0_0000, 64'h0000_0000_3F80_0000, 0, 0, 4'b1000, "R3 strict qnan");
    apply(64'h0000_0000_7FC0_0000, 64'h0000_0000_3F80_0000, 0, 0, 4'b0111, "R2 R1 qnan unordered");
    apply(64'h0000_0000_3F80_0000, 64'h0000_0000_7F80_0001, 0, 0, 4'b0000, "R4 snan non-strict");
    apply(64'h7FF0_0000_0000_0001, 64'h7FF8_0000_0000_0000, 1, 0, 4'b0110, "R2 R4 dbl nan pair");
    apply(64'hFFF0_0000_0000_0000, 64'hBFF0_0000_0000_0000, 1, 0, 4'b0100, "R9 -inf < -1");
    apply(64'h7FF0_0000_0000_0000, 64'h7FF0_0000_0000_0000, 1, 0, 4'b1010, "R5 R10 inf == inf");
    apply(64'h7FF0_0000_0000_0000, 64'h7FF0_0000_0000_0000, 1, 0, 4'b0100, "R10 equal not less");
    apply(64'hFFFF_FFFF_3F80_0000, 64'h0000_0000_3F80_0000, 0, 0, 4'b0010, "R8 upper half ignored");
    apply(64'h7FF8_0000_3F80_0000, 64'h0000_0000_4000_0000, 0, 0, 4'b1100, "R8 upper nan ignored");
    for (int i = 0; i < 3000; i++) begin
      bit d;
      d = $urandom_range(0, 1) == 1;
      a = gen_op(d, int'($urandom_range(0, 6)), 64'h0);
      b = gen_op(d, int'($urandom_range(0, 6)), a);
      apply(a, b, d, $urandom_range(0, 1) == 1, 4'($urandom), "R1 R2 R3 R4 R5 R6 R9 random");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule